// File: doc/BRIEF.md
# Multi-Bank Interrupt Control Unit

This block gathers level-sensitive interrupt requests into several banks of up to 32 sources each. Each bank latches its requests into a pending status vector and combines it with an enable vector into an output status. Each bank drives its own CPU interrupt line. Each bank also reports the position of the highest pending, enabled source, so a dispatcher can pick one source without scanning the register.

Software reaches every bank through a simple 32-bit register bus. Reads return data in the same cycle as the strobe, and writes take effect at the next clock edge. Banks sit at a fixed byte stride in the address space. Pending bits are cleared by writing ones. Masking a source through the enable register keeps its pending bit, so the request is served later when the source is enabled again.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every status bit and every enable bit is 0, every `cpu_irq` line is low and every `irq_idx` field is 0.
- R2: Bank n occupies byte addresses n*0x28 up to n*0x28+0x27. Its registers sit at these offsets: status 0x00, enable 0x08, output status 0x10, raw request 0x18 and mask 0x20. Source k of bank n is request input bit n*32+k. An access to one bank never changes another bank.
- R3: A status bit becomes 1 at any clock edge where its request input is high. It stays 1 until software clears it.
- R4: A write to the status register clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged.
- R5: When a request is high in the same cycle that software writes a 1 to clear its status bit, the bit stays 1.
- R6: A write to the enable register replaces the whole enable vector. Clearing an enable bit leaves the matching status bit unchanged.
- R7: The output status reads as status AND enable. `cpu_irq[n]` is high exactly when the output status of bank n is nonzero.
- R8: `irq_idx` field n (bits n*5 up to n*5+4) holds the position of the most significant set bit of bank n's output status. It is 0 when that output status is 0.
- R9: The raw request register returns the current request inputs of the bank, without latching.
- R10: The mask register reads as the bitwise inverse of the enable register.
- R11: Three cases read as 0: an undefined offset, an address beyond the last bank, and any cycle where `bus_rd` is low. Writes to the output status, raw request and mask registers change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NB*SRC_W | Level interrupt requests; bit n*32+k is source k of bank n |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| cpu_irq | output | NB | Per-bank interrupt line to the CPU |
| irq_idx | output | NB*IDX_W | Per-bank index of the highest pending enabled source |

## Verification
Suppose a status bit is lost, is set without a request, or survives a clearing write. That error shows one clock edge later as a wrong `cpu_irq` level or `irq_idx` value, and as a wrong value in the next status read. A corrupted enable vector shows in the same way through the output status and the mask register. A decode fault shows on the read bus in the cycle of the access. Such faults include an offset hitting the wrong bank or a write landing on a read-only register. The stimulus therefore reads back every register of the banks it touches right after each change and compares the per-bank lines on the following edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int OFS_STATUS = 'h00;
   localparam int OFS_ENABLE = 'h08;
   localparam int OFS_OUTST  = 'h10;
   localparam int OFS_RAW    = 'h18;
   localparam int OFS_MASK   = 'h20;
   localparam int OFS_LAST   = OFS_MASK + 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ENABLE,
      SEL_OUTST,
      SEL_RAW,
      SEL_MASK
   } reg_sel_e;

   function automatic reg_sel_e reg_decode(input logic [31:0] ofs);
      case (ofs)
         32'(OFS_STATUS): return SEL_STATUS;
         32'(OFS_ENABLE): return SEL_ENABLE;
         32'(OFS_OUTST):  return SEL_OUTST;
         32'(OFS_RAW):    return SEL_RAW;
         32'(OFS_MASK):   return SEL_MASK;
         default:         return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
   parameter int W  = 32,
   parameter int IW = 5
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);

   if (W < 1 || (1 << IW) < W) begin : g_bad_width
      $error("irq_msb_find: index width too small");
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/irq_bank_slice.sv
module irq_bank_slice
   import irq_bank_pkg::*;
#(
   parameter int SRC_W  = 32,
   parameter int ADDR_W = 8,
   parameter int BASE   = 0,
   parameter int STRIDE = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  req,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [SRC_W-1:0]  out_vec,
   output logic [SRC_W-1:0]  st_q,
   output logic [SRC_W-1:0]  en_q
);

   localparam int LIMIT = BASE + STRIDE;

   logic [ADDR_W:0]   addr_x;
   logic              hit;
   logic [ADDR_W-1:0] ofs;
   reg_sel_e          sel;
   logic [SRC_W-1:0]  clr;
   logic              en_wr;

   assign addr_x = {1'b0, addr};
   assign hit    = (addr_x >= (ADDR_W+1)'(BASE)) && (addr_x < (ADDR_W+1)'(LIMIT));
   assign ofs    = addr - ADDR_W'(BASE);
   assign sel    = hit ? reg_decode(32'(ofs)) : SEL_NONE;

   assign clr   = (wr && sel == SEL_STATUS) ? wdata[SRC_W-1:0] : '0;
   assign en_wr = wr && (sel == SEL_ENABLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= (st_q & ~clr) | req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         en_q <= wdata[SRC_W-1:0];
      end
   end

   assign out_vec = st_q & en_q;

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_STATUS: rdata = 32'(st_q);
            SEL_ENABLE: rdata = 32'(en_q);
            SEL_OUTST:  rdata = 32'(out_vec);
            SEL_RAW:    rdata = 32'(req);
            SEL_MASK:   rdata = 32'(~en_q);
            default:    rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
   import irq_bank_pkg::*;
#(
   parameter int NB     = 5,
   parameter int SRC_W  = 32,
   parameter int ADDR_W = 8,
   parameter int STRIDE = 40,
   localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NB*SRC_W-1:0]   irq_req,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic [NB-1:0]         cpu_irq,
   output logic [NB*IDX_W-1:0]   irq_idx
);

   if (SRC_W < 1 || SRC_W > 32) begin : g_bad_src
      $error("irq_bank_ctrl: SRC_W must be 1..32");
   end
   if (STRIDE < OFS_LAST || (STRIDE % 4) != 0) begin : g_bad_stride
      $error("irq_bank_ctrl: STRIDE too small or unaligned");
   end
   if (NB < 1 || NB * STRIDE > (1 << ADDR_W)) begin : g_bad_span
      $error("irq_bank_ctrl: banks do not fit the address space");
   end

   logic [NB*SRC_W-1:0]  st_all;
   logic [NB*SRC_W-1:0]  en_all;
   logic [NB-1:0][31:0]  rd_bank;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [SRC_W-1:0] out_b;

      irq_bank_slice #(
         .SRC_W  (SRC_W),
         .ADDR_W (ADDR_W),
         .BASE   (b * STRIDE),
         .STRIDE (STRIDE)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (irq_req[b*SRC_W +: SRC_W]),
         .wr      (bus_wr),
         .rd      (bus_rd),
         .addr    (bus_addr),
         .wdata   (bus_wdata),
         .rdata   (rd_bank[b]),
         .out_vec (out_b),
         .st_q    (st_all[b*SRC_W +: SRC_W]),
         .en_q    (en_all[b*SRC_W +: SRC_W])
      );

      irq_msb_find #(
         .W  (SRC_W),
         .IW (IDX_W)
      ) u_msb (
         .vec (out_b),
         .idx (irq_idx[b*IDX_W +: IDX_W]),
         .any (cpu_irq[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NB; b++) begin
         bus_rdata = bus_rdata | rd_bank[b];
      end
   end

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int NB    = 5,
   parameter int SRC_W = 32,
   parameter int IDX_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NB*SRC_W-1:0]  irq_req,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [31:0]          bus_rdata,
   input logic [NB-1:0]        cpu_irq,
   input logic [NB*IDX_W-1:0]  irq_idx,
   input logic [NB*SRC_W-1:0]  st_all,
   input logic [NB*SRC_W-1:0]  en_all
);

   // R3
   set_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((st_all & $past(irq_req)) == $past(irq_req)));

   // R4
   st_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bus_wr)) |-> (($past(st_all) & ~st_all) == '0));

   // R6
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bus_wr)) |-> $stable(en_all));

   // R11
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == 32'h0));

   for (genvar b = 0; b < NB; b++) begin : g_bank_chk
      // R8
      idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cpu_irq[b] |-> (irq_idx[b*IDX_W +: IDX_W] == '0));

      // R8
      idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq[b] |-> (st_all[b*SRC_W + int'(irq_idx[b*IDX_W +: IDX_W])]
                         && en_all[b*SRC_W + int'(irq_idx[b*IDX_W +: IDX_W])]));
   end

endmodule

bind irq_bank_ctrl irq_bank_chk #(
   .NB    (NB),
   .SRC_W (SRC_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .cpu_irq   (cpu_irq),
   .irq_idx   (irq_idx),
   .st_all    (st_all),
   .en_all    (en_all)
);

// File: tb/test_irq_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_bank_ctrl;

   localparam int NB = 5;
   localparam int SW = 32;
   localparam int IW = 5;
   localparam int ST = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NB*SW-1:0]  irq_req = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NB-1:0]     cpu_irq;
   logic [NB*IW-1:0]  irq_idx;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] st_m [NB];
   logic [31:0] en_m [NB];

   always #2.5 clk = ~clk;

   irq_bank_ctrl i_irq_bank_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cpu_irq   (cpu_irq),
      .irq_idx   (irq_idx)
   );

   // Reference model built from the requirements.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            st_m[b] = '0;
            en_m[b] = '0;
         end
      end else begin
         if (bus_wr && int'(bus_addr) < NB*ST) begin
            if (int'(bus_addr) % ST == 0)
               st_m[int'(bus_addr)/ST] = st_m[int'(bus_addr)/ST] & ~bus_wdata;
            if (int'(bus_addr) % ST == 8)
               en_m[int'(bus_addr)/ST] = bus_wdata;
         end
         for (int b = 0; b < NB; b++) st_m[b] = st_m[b] | irq_req[b*SW +: SW];
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: pops one expected item per read cycle.
   always @(negedge clk) begin
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected read", bus_rdata, 32'h0);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end else if (rst_n) begin
         chk("R11 idle bus", bus_rdata, 32'h0);
      end
   end

   function automatic int msb_of(logic [31:0] v);
      int r = 0;
      for (int i = 0; i < 32; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic ports_chk(string tag);
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         logic [31:0] o;
         o = st_m[b] & en_m[b];
         chk({tag, " cpu_irq"}, 32'(cpu_irq[b]), 32'(o != 0));
         chk({tag, " idx"}, 32'(irq_idx[b*IW +: IW]), 32'(msb_of(o)));
      end
      @(posedge clk); #1;
   endtask

   task automatic rd_abs(int a, logic [31:0] exp, string tag);
      bus_rd = 1'b1;
      bus_addr = 8'(a);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic rd(int n, int ofs, logic [31:0] exp, string tag);
      rd_abs(n*ST + ofs, exp, tag);
   endtask

   task automatic wr(int n, int ofs, logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = 8'(n*ST + ofs);
      bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic pulse(int g);
      irq_req[g] = 1'b1;
      @(posedge clk); #1;
      irq_req[g] = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      ports_chk("R1 reset");
      for (int b = 0; b < NB; b++) begin
         rd(b, 0, 32'h0, "R1 status");
         rd(b, 8, 32'h0, "R1 enable");
      end

      // R3 latch of a one-cycle request, masked at the output
      pulse(3);
      ports_chk("R3 masked");
      rd(0, 0, 32'h8, "R3 status");
      rd(0, 16, 32'h0, "R7 masked out");

      // R7 enabling drives the line
      wr(0, 8, 32'h8);
      ports_chk("R7 enabled");
      rd(0, 16, 32'h8, "R7 out");

      // R8 most significant source wins
      wr(0, 8, 32'hFFFF_FFFF);
      pulse(17);
      ports_chk("R8 msb");
      rd(0, 16, 32'h0002_0008, "R7 two sources");

      // R4 write-one-to-clear
      wr(0, 0, 32'h0);
      rd(0, 0, 32'h0002_0008, "R4 zero write");
      wr(0, 0, 32'h0002_0000);
      rd(0, 0, 32'h8, "R4 clear bit17");
      ports_chk("R4 after clear");

      // R5 set beats clear
      irq_req[3] = 1'b1;
      wr(0, 0, 32'h8);
      irq_req[3] = 1'b0;
      rd(0, 0, 32'h8, "R5 set priority");

      // R6 masking keeps pending
      wr(0, 8, 32'h0);
      ports_chk("R6 disabled");
      rd(0, 0, 32'h8, "R6 pending kept");
      wr(0, 8, 32'h8);
      ports_chk("R6 re-enabled");

      // R9 raw requests
      irq_req[2*SW +: SW] = 32'hA5A5_0F0F;
      rd(2, 24, 32'hA5A5_0F0F, "R9 raw");
      irq_req[2*SW +: SW] = '0;
      rd(2, 24, 32'h0, "R9 raw released");
      rd(2, 0, 32'hA5A5_0F0F, "R3 bank2 latched");

      // R10 mask register, R2 isolation
      wr(1, 8, 32'h0000_F0F0);
      rd(1, 32, 32'hFFFF_0F0F, "R10 mask");
      rd(0, 8, 32'h8, "R2 bank0 enable untouched");
      rd(1, 0, 32'h0, "R2 bank1 status");

      // R2 last bank, top source
      pulse(4*SW + 31);
      wr(4, 8, 32'h8000_0000);
      ports_chk("R2 last bank");
      rd(4, 16, 32'h8000_0000, "R2 last bank out");

      // R11 undefined offsets and read-only writes
      rd(0, 4, 32'h0, "R11 offset 04");
      rd(0, 36, 32'h0, "R11 offset 24");
      rd_abs(240, 32'h0, "R11 beyond banks");
      wr(0, 16, 32'hFFFF_FFFF);
      wr(0, 24, 32'hFFFF_FFFF);
      wr(0, 32, 32'hFFFF_FFFF);
      rd(0, 0, 32'h8, "R11 status after ro writes");
      rd(0, 8, 32'h8, "R11 enable after ro writes");
      ports_chk("R11 lines");

      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule